// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This peripheral holds several independent 32-bit down counters behind a simple synchronous register port. Each channel keeps an interval value, a live count and a control word. Once started, a channel moves one step on every cycle in which the shared count-enable input `tick` is high. That input stands for the selected timer source clock. When a channel's count is zero at a tick, the channel expires. A periodic channel then reloads its interval and keeps running. A one-shot channel stops instead and clears its own enable bit.

Each expiry sets that channel's bit in a shared pending register. Software clears a bit there by writing one to it. A shared mask register decides which pending bits drive the single interrupt line. Clearing a channel's enable does not stop it at once: the channel keeps counting for a fixed number of further ticks before it halts, so software must wait a few ticks of another channel before it reprograms this one.

An interval of all ones in periodic mode gives a free-running counter that wraps without end. Its bitwise inverse reads as a rising timestamp.

Top module: `mmio_down_timer`

## Requirements
- R1: After reset every register reads zero, every channel is idle and `irq` is low.
- R2: Address map: 0x00 is the interrupt mask (bit n for channel n) and 0x04 is the pending register. Channel n occupies base 0x10+0x10·n: control at +0x0, interval at +0x4, count at +0x8. Control fields are bit 0 enable, bit 1 reload, bits 3:2 source select and bit 7 one-shot. The reload bit acts only at the time of the write and reads as zero. Reserved bits and unmapped addresses read as zero.
- R3: A control write with enable and reload both set copies the interval into the count one cycle later and starts the channel.
- R4: A running channel whose count is non-zero decrements it by one on each tick. A channel that is idle holds its count.
- R5: A channel expires when its count is zero at a tick, so an interval of N gives N+1 ticks per period. In periodic mode (one-shot clear), expiry reloads the interval and counting continues.
- R6: In one-shot mode, expiry stops the channel, clears its enable bit and leaves the count at zero. Later ticks change nothing.
- R7: Expiry sets the channel's pending bit whether or not its mask bit is set. `irq` is high exactly when some pending bit and its mask bit are both set.
- R8: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R9: If a clear of a pending bit and a new expiry of that channel fall in the same cycle, the bit stays set.
- R10: After enable is cleared, the control reads enable 0 at once, but the channel keeps its previous counting for SYNC_TICKS (default 2) more ticks and then halts.
- R11: The count register is read-only: writes to it are ignored. An all-ones interval in periodic mode wraps continuously, and the inverse of its count rises by one per tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one pulse per source-clock period |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt: OR of pending bits that are masked in |

## Verification
A software clear of a pending bit and a fresh expiry of the same channel can land in the same clock cycle. The bench sets up a channel with interval zero, so that every tick is an expiry. It then issues the write-one-to-clear in the very cycle where `tick` is high, and expects the pending bit to read back as set. A second clear with `tick` low must then empty the bit. This shows that the set path has priority over the clear and that the clear itself is not lost.

// File: rtl/mmio_down_timer.sv
module mmio_down_timer #(
  parameter int NUM_CH     = 2,
  parameter int ADDR_W     = 8,
  parameter int SYNC_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int DW      = $clog2(SYNC_TICKS + 1);
  localparam int CH_BASE = 16;
  localparam int CH_STEP = 16;

  logic [NUM_CH-1:0] ie_q, st_q, en_q, os_q;
  logic [1:0]        src_q  [NUM_CH];
  logic [31:0]       ivl_q  [NUM_CH];
  logic [31:0]       cnt_q  [NUM_CH];
  logic [DW-1:0]     drain_q[NUM_CH];
  logic [NUM_CH-1:0] run, expire, ctl_wr, ivl_wr, load;

  wire ie_wr = bus_we && (bus_addr == ADDR_W'(0));
  wire st_wr = bus_we && (bus_addr == ADDR_W'(4));

  assign irq = |(st_q & ie_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q <= '0;
      st_q <= '0;
    end else begin
      if (ie_wr) ie_q <= bus_wdata[NUM_CH-1:0];
      st_q <= (st_q & ~(st_wr ? bus_wdata[NUM_CH-1:0] : '0)) | expire;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int BASE = CH_BASE + CH_STEP * g;

    assign ctl_wr[g] = bus_we && (bus_addr == ADDR_W'(BASE));
    assign ivl_wr[g] = bus_we && (bus_addr == ADDR_W'(BASE + 4));
    assign load[g]   = ctl_wr[g] && bus_wdata[0] && bus_wdata[1];
    assign run[g]    = en_q[g] || (drain_q[g] != '0);
    assign expire[g] = run[g] && tick && (cnt_q[g] == '0) && !load[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q[g]    <= 1'b0;
        os_q[g]    <= 1'b0;
        src_q[g]   <= '0;
        ivl_q[g]   <= '0;
        cnt_q[g]   <= '0;
        drain_q[g] <= '0;
      end else begin
        if (ivl_wr[g]) ivl_q[g] <= bus_wdata;

        if (run[g] && tick && drain_q[g] != '0) drain_q[g] <= drain_q[g] - 1'b1;

        if (load[g]) begin
          cnt_q[g] <= ivl_q[g];
        end else if (run[g] && tick) begin
          if (cnt_q[g] != '0) begin
            cnt_q[g] <= cnt_q[g] - 1'b1;
          end else if (os_q[g]) begin
            en_q[g]    <= 1'b0;
            drain_q[g] <= '0;
          end else begin
            cnt_q[g] <= ivl_q[g];
          end
        end

        if (ctl_wr[g]) begin
          en_q[g]  <= bus_wdata[0];
          src_q[g] <= bus_wdata[3:2];
          os_q[g]  <= bus_wdata[7];
          if (bus_wdata[0])     drain_q[g] <= '0;
          else if (en_q[g])     drain_q[g] <= DW'(SYNC_TICKS);
        end
      end
    end

    // R3
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load[g] |=> cnt_q[g] == $past(ivl_q[g]));
    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[g] && !load[g]) |=> $stable(cnt_q[g]));
    // R5
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[g] && !os_q[g]) |=> cnt_q[g] == $past(ivl_q[g]));
    // R6
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[g] && os_q[g] && !ctl_wr[g]) |=> !run[g]);
    // R7
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire[g] |=> st_q[g]);
    // R8
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && bus_wdata[g] && !expire[g]) |=> !st_q[g]);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(0)) bus_rdata[NUM_CH-1:0] = ie_q;
    if (bus_addr == ADDR_W'(4)) bus_rdata[NUM_CH-1:0] = st_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(CH_BASE + CH_STEP * i))
        bus_rdata = {24'b0, os_q[i], 3'b0, src_q[i], 1'b0, en_q[i]};
      if (bus_addr == ADDR_W'(CH_BASE + CH_STEP * i + 4)) bus_rdata = ivl_q[i];
      if (bus_addr == ADDR_W'(CH_BASE + CH_STEP * i + 8)) bus_rdata = cnt_q[i];
    end
  end
endmodule

// File: tb/mmio_down_timer_tb.sv
module mmio_down_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq;
  int          n_run = 0, n_fail = 0;

  mmio_down_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h00, v); check("R1 mask", v, 0);
    rd(8'h04, v); check("R1 pending", v, 0);
    rd(8'h10, v); check("R1 ctrl0", v, 0);
    rd(8'h28, v); check("R1 count1", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_periodic;
    logic [31:0] v;
    wr(8'h14, 5); wr(8'h10, 3);
    rd(8'h18, v); check("R3 load", v, 5);
    rd(8'h10, v); check("R2 reload reads 0", v, 1);
    ticks(3); rd(8'h18, v); check("R4 decrement", v, 2);
    ticks(2); rd(8'h04, v); check("R5 no early expiry", v, 0);
    ticks(1); rd(8'h18, v); check("R5 reload", v, 5);
    rd(8'h04, v); check("R7 pending without mask", v, 1);
    check("R7 irq masked off", {31'b0, irq}, 0);
  endtask

  task automatic t_irq_clear;
    logic [31:0] v;
    wr(8'h00, 1); check("R7 irq on", {31'b0, irq}, 1);
    wr(8'h04, 0); rd(8'h04, v); check("R8 write 0 keeps", v, 1);
    wr(8'h04, 1); rd(8'h04, v); check("R8 write 1 clears", v, 0);
    check("R8 irq off", {31'b0, irq}, 0);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    wr(8'h24, 2); wr(8'h20, 32'h83);
    ticks(3);
    rd(8'h04, v); check("R6 pending", v & 2, 2);
    rd(8'h20, v); check("R6 enable cleared", v, 32'h80);
    rd(8'h28, v); check("R6 count zero", v, 0);
    wr(8'h04, 2); ticks(4);
    rd(8'h28, v); check("R6 stays stopped", v, 0);
    rd(8'h04, v); check("R6 no re-expiry", v & 2, 0);
    wr(8'h04, 3);
  endtask

  task automatic t_drain;
    logic [31:0] v;
    wr(8'h14, 100); wr(8'h10, 3);
    ticks(4); rd(8'h18, v); check("R4 count 96", v, 96);
    wr(8'h10, 0); rd(8'h10, v); check("R10 enable reads 0", v, 0);
    ticks(2); rd(8'h18, v); check("R10 keeps counting", v, 94);
    ticks(5); rd(8'h18, v); check("R10 halted", v, 94);
    wr(8'h18, 32'h1234); rd(8'h18, v); check("R11 count read-only", v, 94);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    wr(8'h14, 0); wr(8'h10, 3);
    ticks(1); rd(8'h04, v); check("R9 setup pending", v & 1, 1);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 8'h04; bus_wdata = 1; tick = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; tick = 1'b0;
    rd(8'h04, v); check("R9 expiry wins", v & 1, 1);
    wr(8'h04, 1); rd(8'h04, v); check("R9 later clear", v & 1, 0);
    wr(8'h10, 0); ticks(3);
  endtask

  task automatic t_free;
    logic [31:0] v;
    wr(8'h24, 32'hFFFF_FFFF); wr(8'h20, 3);
    rd(8'h28, v); check("R11 all ones", v, 32'hFFFF_FFFF);
    ticks(3); rd(8'h28, v); check("R11 timestamp", ~v, 3);
    wr(8'h24, 32'h0000_0001); wr(8'h20, 3);
    ticks(2); rd(8'h28, v); check("R5 wrap", v, 1);
  endtask

  task automatic t_reserved;
    logic [31:0] v;
    wr(8'h10, 32'hFFFF_FF7C); rd(8'h10, v); check("R2 reserved zero", v, 32'h0C);
    rd(8'h40, v); check("R2 unmapped", v, 0);
    rd(8'h18, v); ticks(2);
    begin
      logic [31:0] w;
      rd(8'h18, w); check("R4 idle holds", w, v);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_periodic();
    t_irq_clear();
    t_oneshot();
    t_drain();
    t_collide();
    t_free();
    t_reserved();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule